// File: doc/BRIEF.md
# Two-wire controller register bank

This block is the software-visible register file of a two-wire serial controller. A simple processor bus reaches it with a 32-bit byte address, a byte count, separate read and write strobes and 16-bit data. Every register is one 16-bit halfword on a 4-byte stride. The bank covers these registers:

- clock divider and general control;
- slave control, slave address, master control and master address;
- slave, master, interrupt and FIFO status;
- interrupt mask and FIFO control;
- a single-entry transmit holding register and a single-entry receive holding register.

The controller core drives the status registers through sideband inputs. Interrupt status and the master error bits are sticky and software clears them by writing ones. The other status bits track level inputs.

Reads are combinational and have no side effects. Writes take effect at the next rising clock edge. Every access reports a 2-bit error code in the same cycle. A rejected access changes no state. The interrupt output goes high whenever an enabled interrupt status bit is set.

Top module: `tw_reg_bank`

Register map, as byte offsets from `BASE_ADDR`:

| Offset | Register |
|---|---|
| 0x00 | clock divider |
| 0x04 | control |
| 0x08 | slave control |
| 0x0C | slave status |
| 0x10 | slave address |
| 0x14 | master control |
| 0x18 | master status |
| 0x1C | master address |
| 0x20 | interrupt status |
| 0x24 | interrupt mask |
| 0x28 | FIFO control |
| 0x2C | FIFO status |
| 0x80 | byte-wide transmit port |
| 0x84 | halfword transmit port |
| 0x88 | byte-wide receive port |
| 0x8C | halfword receive port |

Offsets 0x30 to 0x7C are a reserved gap.

## Requirements
- R1: After reset every register and the transmit and receive holding registers read zero, and `irq_o` is low.
- R2: Any read or write whose `size_i` is not 2 gives `err_o` = 1 and changes no state. This holds even at an unmapped address, where the size error takes priority over the mapping error.
- R3: A 2-byte access to an address outside the map gives `err_o` = 2, reads zero and changes no state. Outside the map means misaligned, inside the reserved gap, at or beyond offset 0x90, or below the base.
- R4: The eight plain registers read back the last value written and drive their configuration outputs. These are clock divider, control, slave control, slave address, master control, master address, interrupt mask and FIFO control.
- R5: A write to interrupt status clears each bit written as one and keeps each bit written as zero. Bits are set by one-cycle pulses on `int_set_i`.
- R6: In master status, only bit 1 (lost arbitration), bit 2 (address NAK), bit 3 (data NAK), bit 4 (read-buffer error) and bit 5 (write-buffer error) are sticky. They are set by `mst_stat_i` and cleared by writing one. All other master status bits follow `mst_stat_i` one cycle later and ignore writes.
- R7: Writes to slave status, FIFO status and both receive ports report `err_o` = 0 and change nothing. Slave and FIFO status follow `slv_stat_i` and `fifo_stat_i` one cycle later.
- R8: A write to offset 0x80 stores the low 8 bits, zero-extended, into the transmit holding register. A write to 0x84 stores all 16 bits. Both ports read zero, and `tx_data_o` shows the held value.
- R9: `rx_load_i` loads `rx_data_i` into the receive holding register. Offsets 0x88 and 0x8C both return it.
- R10: When a set input and a software clear hit the same sticky status bit in the same cycle, the bit ends up set.
- R11: `irq_o` is high exactly when the bitwise AND of interrupt status and interrupt mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 32 | Byte address |
| size_i | input | 3 | Access size in bytes |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, zero on error |
| err_o | output | 2 | 0 ok, 1 bad size, 2 unmapped |
| int_set_i | input | 16 | Interrupt status set pulses |
| mst_stat_i | input | 16 | Master status: set pulses on error bits, levels elsewhere |
| slv_stat_i | input | 16 | Slave status levels |
| fifo_stat_i | input | 16 | FIFO status levels |
| rx_load_i | input | 1 | Load receive holding register |
| rx_data_i | input | 16 | Received data |
| tx_data_o | output | 16 | Transmit holding register |
| irq_o | output | 1 | Interrupt request |
| clk_div_o | output | 16 | Clock divider value |
| ctrl_o | output | 16 | Control value |
| slv_ctrl_o | output | 16 | Slave control value |
| slv_addr_o | output | 16 | Slave address value |
| mst_ctrl_o | output | 16 | Master control value |
| mst_addr_o | output | 16 | Master address value |
| fifo_ctrl_o | output | 16 | FIFO control value |

## Verification
The bench sends a byte-sized access into the reserved gap. A decoder that checks the address first would return code 2 there instead of 1. The bench writes all ones to master status, then drives a level bit outside the error field and writes it. A register that cleared the whole halfword, or latched the write data, would lose or corrupt that bit. The byte transmit port is written with a value whose upper byte is nonzero. The bench also reads the transmit ports, which exposes a missing mask or a read path that returns the held data instead of zero. Finally, a set pulse lands in the same cycle as a clear of the same interrupt bit. A clear-wins register would drop the bit and leave `irq_o` low.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int DW          = 16;
  localparam int BYTE_W      = 8;
  localparam int NSLOT       = 16;
  localparam int CORE_WORDS  = 12;
  localparam int DATA_WORD0  = 32;  // first data port word, offset 0x80
  localparam int DATA_WORDS  = 4;

  typedef enum logic [3:0] {
    S_CLKDIV, S_CTRL, S_SLV_CTRL, S_SLV_STAT, S_SLV_ADDR, S_MST_CTRL,
    S_MST_STAT, S_MST_ADDR, S_INT_STAT, S_INT_MASK, S_FIFO_CTRL, S_FIFO_STAT,
    S_TX8, S_TX16, S_RX8, S_RX16
  } slot_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_SIZE = 2'd1,
    ERR_MAP  = 2'd2
  } err_e;

  // lost-arb 1, addr-nak 2, data-nak 3, rd-buf 4, wr-buf 5
  localparam logic [DW-1:0] MST_ERR_MASK = 16'h003E;

  function automatic bit slot_is_rw(int i);
    return i == int'(S_CLKDIV)   || i == int'(S_CTRL)     ||
           i == int'(S_SLV_CTRL) || i == int'(S_SLV_ADDR) ||
           i == int'(S_MST_CTRL) || i == int'(S_MST_ADDR) ||
           i == int'(S_INT_MASK) || i == int'(S_FIFO_CTRL);
  endfunction
endpackage

// File: rtl/tw_decode.sv
module tw_decode
  import tw_pkg::*;
#(
  parameter int          AW        = 32,
  parameter logic [AW-1:0] BASE_ADDR = '0,
  parameter int          ACC_BYTES = 2
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [2:0]       size_i,
  input  logic             rd_i,
  input  logic             wr_i,
  output logic [NSLOT-1:0] sel_o,
  output err_e             err_o
);
  localparam int WW = AW - 2;

  logic [AW-1:0] off;
  logic [WW-1:0] word;
  logic [WW-1:0] dword;
  logic          hit;
  logic [3:0]    idx;
  logic          access;

  assign off    = addr_i - BASE_ADDR;
  assign word   = off[AW-1:2];
  assign dword  = word - WW'(DATA_WORD0);
  assign access = rd_i | wr_i;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (off[1:0] == 2'b00) begin
      if (word < WW'(CORE_WORDS)) begin
        hit = 1'b1;
        idx = 4'(word);
      end else if (word >= WW'(DATA_WORD0) &&
                   word < WW'(DATA_WORD0 + DATA_WORDS)) begin
        hit = 1'b1;
        idx = 4'(dword) + 4'(CORE_WORDS);
      end
    end
  end

  // size check outranks map check
  always_comb begin
    err_o = ERR_NONE;
    sel_o = '0;
    if (access) begin
      if (size_i != 3'(ACC_BYTES)) err_o = ERR_SIZE;
      else if (!hit)               err_o = ERR_MAP;
      else                         sel_o = NSLOT'(1) << idx;
    end
  end
endmodule

// File: rtl/tw_stat_reg.sv
module tw_stat_reg #(
  parameter int             W      = 16,
  parameter logic [W-1:0]   STICKY = '1,
  parameter logic [W-1:0]   CLR    = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (STICKY[b]) begin : g_sticky
      logic clr_b;
      assign clr_b = clr_en_i & clr_i[b] & CLR[b];
      // set beats clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o[b] <= 1'b0;
        else         q_o[b] <= (q_o[b] & ~clr_b) | in_i[b];
      end
    end else begin : g_level
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o[b] <= 1'b0;
        else         q_o[b] <= in_i[b];
      end
    end
  end
endmodule

// File: rtl/tw_rdmux.sv
module tw_rdmux
  import tw_pkg::*;
(
  input  logic [NSLOT-1:0][DW-1:0] slot_i,
  input  logic [NSLOT-1:0]         sel_i,
  input  logic                     rd_i,
  output logic [DW-1:0]            rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (rd_i && sel_i[i]) rdata_o = rdata_o | slot_i[i];
    end
  end
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
  import tw_pkg::*;
#(
  parameter int              AW        = 32,
  parameter logic [AW-1:0]   BASE_ADDR = 32'h0000_1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    size_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    err_o,
  input  logic [DW-1:0] int_set_i,
  input  logic [DW-1:0] mst_stat_i,
  input  logic [DW-1:0] slv_stat_i,
  input  logic [DW-1:0] fifo_stat_i,
  input  logic          rx_load_i,
  input  logic [DW-1:0] rx_data_i,
  output logic [DW-1:0] tx_data_o,
  output logic          irq_o,
  output logic [DW-1:0] clk_div_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] slv_ctrl_o,
  output logic [DW-1:0] slv_addr_o,
  output logic [DW-1:0] mst_ctrl_o,
  output logic [DW-1:0] mst_addr_o,
  output logic [DW-1:0] fifo_ctrl_o
);
  logic [NSLOT-1:0]         sel;
  err_e                     err;
  logic [NSLOT-1:0][DW-1:0] rd_slot;
  logic [DW-1:0]            int_q, mst_q, slv_q, fifo_q;
  logic [DW-1:0]            tx_q, rx_q;

  tw_decode #(.AW(AW), .BASE_ADDR(BASE_ADDR), .ACC_BYTES(2)) u_dec (
    .addr_i(addr_i), .size_i(size_i), .rd_i(rd_i), .wr_i(wr_i),
    .sel_o(sel), .err_o(err)
  );
  assign err_o = err;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (slot_is_rw(i)) begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            q <= '0;
        else if (wr_i && sel[i]) q <= wdata_i;
      end
      assign rd_slot[i] = q;
    end else if (i == int'(S_SLV_STAT)) begin : g_slv
      assign rd_slot[i] = slv_q;
    end else if (i == int'(S_MST_STAT)) begin : g_mst
      assign rd_slot[i] = mst_q;
    end else if (i == int'(S_INT_STAT)) begin : g_int
      assign rd_slot[i] = int_q;
    end else if (i == int'(S_FIFO_STAT)) begin : g_fifo
      assign rd_slot[i] = fifo_q;
    end else if (i == int'(S_RX8) || i == int'(S_RX16)) begin : g_rx
      assign rd_slot[i] = rx_q;
    end else begin : g_tx
      assign rd_slot[i] = '0;  // transmit ports are write-only
    end
  end

  tw_stat_reg #(.W(DW), .STICKY('1), .CLR('1)) u_int (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(int_set_i),
    .clr_en_i(wr_i & sel[S_INT_STAT]), .clr_i(wdata_i), .q_o(int_q)
  );

  tw_stat_reg #(.W(DW), .STICKY(MST_ERR_MASK), .CLR(MST_ERR_MASK)) u_mst (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(mst_stat_i),
    .clr_en_i(wr_i & sel[S_MST_STAT]), .clr_i(wdata_i), .q_o(mst_q)
  );

  tw_stat_reg #(.W(DW), .STICKY('0), .CLR('0)) u_slv (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(slv_stat_i),
    .clr_en_i(1'b0), .clr_i('0), .q_o(slv_q)
  );

  tw_stat_reg #(.W(DW), .STICKY('0), .CLR('0)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(fifo_stat_i),
    .clr_en_i(1'b0), .clr_i('0), .q_o(fifo_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tx_q <= '0;
    else if (wr_i && sel[S_TX8])  tx_q <= {{(DW-BYTE_W){1'b0}}, wdata_i[BYTE_W-1:0]};
    else if (wr_i && sel[S_TX16]) tx_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rx_q <= '0;
    else if (rx_load_i) rx_q <= rx_data_i;
  end

  tw_rdmux u_mux (.slot_i(rd_slot), .sel_i(sel), .rd_i(rd_i), .rdata_o(rdata_o));

  assign irq_o       = |(int_q & rd_slot[S_INT_MASK]);
  assign tx_data_o   = tx_q;
  assign clk_div_o   = rd_slot[S_CLKDIV];
  assign ctrl_o      = rd_slot[S_CTRL];
  assign slv_ctrl_o  = rd_slot[S_SLV_CTRL];
  assign slv_addr_o  = rd_slot[S_SLV_ADDR];
  assign mst_ctrl_o  = rd_slot[S_MST_CTRL];
  assign mst_addr_o  = rd_slot[S_MST_ADDR];
  assign fifo_ctrl_o = rd_slot[S_FIFO_CTRL];
endmodule

// File: rtl/tw_reg_bank_chk.sv
module tw_reg_bank_chk
  import tw_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_i,
  input logic             wr_i,
  input logic [2:0]       size_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic [1:0]       err_o,
  input logic [NSLOT-1:0] sel,
  input logic [DW-1:0]    int_q,
  input logic [DW-1:0]    mst_q,
  input logic [DW-1:0]    int_set_i,
  input logic [DW-1:0]    mst_stat_i,
  input logic [DW-1:0]    clk_div_o,
  input logic [DW-1:0]    tx_data_o
);
  // R2
  size_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) && size_i != 3'd2 |-> err_o == 2'd1);

  // R3
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && err_o != 2'd0 |=> $stable(clk_div_o) && $stable(tx_data_o));

  // R5
  int_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && sel[S_INT_STAT] && int_set_i == '0 |=> (int_q & $past(wdata_i)) == '0);

  // R6
  mst_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && sel[S_MST_STAT] |=>
      (mst_q & ~MST_ERR_MASK) == ($past(mst_stat_i) & ~MST_ERR_MASK));

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_set_i != '0 |=> (int_q & $past(int_set_i)) == $past(int_set_i));

  // R8
  tx_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (sel[S_TX8] || sel[S_TX16]) |-> rdata_o == '0);
endmodule

bind tw_reg_bank tw_reg_bank_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i), .size_i(size_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o), .sel(sel),
  .int_q(int_q), .mst_q(mst_q), .int_set_i(int_set_i), .mst_stat_i(mst_stat_i),
  .clk_div_o(clk_div_o), .tx_data_o(tx_data_o)
);

// File: tb/tw_reg_bank_test.sv
module tw_reg_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [2:0]  size = 3'd2;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  err;
  logic [15:0] int_set = '0, mst_stat = '0, slv_stat = '0, fifo_stat = '0;
  logic        rx_load = 1'b0;
  logic [15:0] rx_data = '0;
  logic [15:0] tx_data, clk_div, ctrl, slv_ctrl, slv_addr, mst_ctrl, mst_addr, fifo_ctrl;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_reg_bank #(.BASE_ADDR(BASE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .size_i(size), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .int_set_i(int_set),
    .mst_stat_i(mst_stat), .slv_stat_i(slv_stat), .fifo_stat_i(fifo_stat),
    .rx_load_i(rx_load), .rx_data_i(rx_data), .tx_data_o(tx_data), .irq_o(irq),
    .clk_div_o(clk_div), .ctrl_o(ctrl), .slv_ctrl_o(slv_ctrl), .slv_addr_o(slv_addr),
    .mst_ctrl_o(mst_ctrl), .mst_addr_o(mst_addr), .fifo_ctrl_o(fifo_ctrl)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] off, input logic [2:0] sz,
                        input logic [15:0] d, output logic [1:0] e);
    @(negedge clk);
    addr = BASE + off; size = sz; wdata = d; wr = 1'b1;
    #1 e = err;
    @(negedge clk);
    wr = 1'b0; size = 3'd2;
  endtask

  task automatic bus_rd(input logic [31:0] off, input logic [2:0] sz,
                        output logic [15:0] d, output logic [1:0] e);
    @(negedge clk);
    addr = BASE + off; size = sz; rd = 1'b1;
    #1 d = rdata; e = err;
    rd = 1'b0; size = 3'd2;
  endtask

  task automatic rd_chk(input string req, input logic [31:0] off, input logic [15:0] exp);
    logic [15:0] d; logic [1:0] e;
    bus_rd(off, 3'd2, d, e);
    chk(req, d, exp);
  endtask

  task automatic wr_ok(input string req, input logic [31:0] off, input logic [15:0] d);
    logic [1:0] e;
    bus_wr(off, 3'd2, d, e);
    chk(req, 16'(e), 16'd0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 12; i++) rd_chk("R1 reg", 32'(i * 4), 16'h0);
    rd_chk("R1 rx", 32'h88, 16'h0);
    chk("R1 tx_data_o", tx_data, 16'h0);
    chk("R1 irq_o", 16'(irq), 16'h0);
  endtask

  task automatic t_rw;
    logic [31:0] offs [8] = '{32'h00, 32'h04, 32'h08, 32'h10, 32'h14, 32'h1C, 32'h24, 32'h28};
    for (int i = 0; i < 8; i++) wr_ok("R4 wr", offs[i], {4'(i + 1), 12'hA5C});
    for (int i = 0; i < 8; i++) rd_chk("R4 rd", offs[i], {4'(i + 1), 12'hA5C});
    chk("R4 clk_div_o", clk_div, 16'h1A5C);
    chk("R4 slv_addr_o", slv_addr, 16'h4A5C);
    chk("R4 fifo_ctrl_o", fifo_ctrl, 16'h8A5C);
    wr_ok("R4 mask clr", 32'h24, 16'h0000);
  endtask

  task automatic t_int;
    @(negedge clk); int_set = 16'h00F3;
    @(negedge clk); int_set = 16'h0000;
    rd_chk("R5 set", 32'h20, 16'h00F3);
    wr_ok("R5 w1c", 32'h20, 16'h0031);
    rd_chk("R5 after clear", 32'h20, 16'h00C2);
    wr_ok("R11 mask", 32'h24, 16'h0080);
    chk("R11 irq high", 16'(irq), 16'h1);
    wr_ok("R11 mask", 32'h24, 16'h0001);
    chk("R11 irq low", 16'(irq), 16'h0);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    addr = BASE + 32'h20; size = 3'd2; wdata = 16'h0043; wr = 1'b1; int_set = 16'h0001;
    @(negedge clk);
    wr = 1'b0; int_set = 16'h0000;
    rd_chk("R10 set beats clear", 32'h20, 16'h0081);
    chk("R11 irq after set", 16'(irq), 16'h1);
  endtask

  task automatic t_mst;
    @(negedge clk); mst_stat = 16'h003F;
    @(negedge clk); mst_stat = 16'h0001;
    @(negedge clk);
    rd_chk("R6 sticky+level", 32'h18, 16'h003F);
    wr_ok("R6 w1c", 32'h18, 16'hFFFF);
    rd_chk("R6 error bits only", 32'h18, 16'h0001);
    @(negedge clk); mst_stat = 16'h8001;
    @(negedge clk);
    wr_ok("R6 w1c level", 32'h18, 16'h8001);
    rd_chk("R6 level ignores write", 32'h18, 16'h8001);
    @(negedge clk); mst_stat = 16'h0000;
    @(negedge clk);
    rd_chk("R6 level follows", 32'h18, 16'h0000);
  endtask

  task automatic t_ignored;
    @(negedge clk); slv_stat = 16'h1234; fifo_stat = 16'h0F0F;
    rx_load = 1'b1; rx_data = 16'hBEEF;
    @(negedge clk); rx_load = 1'b0; rx_data = 16'h0000;
    wr_ok("R7 slv wr err", 32'h0C, 16'hFFFF);
    wr_ok("R7 fifo wr err", 32'h2C, 16'h0000);
    wr_ok("R7 rx8 wr err", 32'h88, 16'h0000);
    wr_ok("R7 rx16 wr err", 32'h8C, 16'h1111);
    rd_chk("R7 slv status", 32'h0C, 16'h1234);
    rd_chk("R7 fifo status", 32'h2C, 16'h0F0F);
    rd_chk("R9 rx8", 32'h88, 16'hBEEF);
    rd_chk("R9 rx16", 32'h8C, 16'hBEEF);
  endtask

  task automatic t_tx;
    wr_ok("R8 tx8 wr", 32'h80, 16'hABCD);
    chk("R8 tx8 masked", tx_data, 16'h00CD);
    rd_chk("R8 tx8 reads 0", 32'h80, 16'h0000);
    wr_ok("R8 tx16 wr", 32'h84, 16'hABCD);
    chk("R8 tx16 full", tx_data, 16'hABCD);
    rd_chk("R8 tx16 reads 0", 32'h84, 16'h0000);
  endtask

  task automatic t_size;
    logic [1:0] e; logic [15:0] d;
    bus_wr(32'h00, 3'd1, 16'h0BAD, e);
    chk("R2 size1 err", 16'(e), 16'd1);
    bus_wr(32'h00, 3'd4, 16'h0BAD, e);
    chk("R2 size4 err", 16'(e), 16'd1);
    rd_chk("R2 clkdiv kept", 32'h00, 16'h1A5C);
    bus_wr(32'h84, 3'd1, 16'h5555, e);
    chk("R2 tx kept", tx_data, 16'hABCD);
    bus_rd(32'h40, 3'd1, d, e);
    chk("R2 priority over map", 16'(e), 16'd1);
  endtask

  task automatic t_map;
    logic [1:0] e; logic [15:0] d;
    logic [31:0] bad [5] = '{32'h40, 32'h02, 32'h86, 32'h90, 32'hFFFF_FFFC};
    for (int i = 0; i < 5; i++) begin
      bus_wr(bad[i], 3'd2, 16'h0BAD, e);
      chk("R3 wr err", 16'(e), 16'd2);
    end
    rd_chk("R3 clkdiv kept", 32'h00, 16'h1A5C);
    chk("R3 tx kept", tx_data, 16'hABCD);
    bus_rd(32'h7C, 3'd2, d, e);
    chk("R3 rd err", 16'(e), 16'd2);
    chk("R3 rd zero", d, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_rw();
    t_int();
    t_set_wins();
    t_mst();
    t_ignored();
    t_tx();
    t_size();
    t_map();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule